// File: doc/BRIEF.md
# Interrupt and Exception Entry Sequencer

This block sits next to a 32-bit processor core and handles the step from normal execution into a handler. It takes in the core's live status word, program counter and stack pointers, along with three request sources: a normal maskable interrupt, a fast interrupt and a synchronous exception or trap. Each cycle it decides whether a request can be accepted. It then runs the matching entry sequence and returns the new program counter, the new status word and the updated stack pointers for the core to load.

A fast interrupt saves the old program counter and status word into dedicated backup registers and jumps to a fast-vector register in a single step. It makes no memory accesses. Normal interrupts and exceptions push the status word and then the program counter onto the interrupt stack. They then read the handler address from a vector table through one word-wide memory port with a valid/ready handshake. Low exception numbers use a fixed table at the top of the address space. Interrupts and unconditional traps use a relocatable base. Typical exception numbers are 20 (privilege violation), 21 (access fault), 23 (illegal instruction), 25 (floating-point fault) and 30 (non-maskable interrupt).

The status word layout is: bit 16 is the interrupt-enable flag (I), bit 17 is the user-stack flag (U), bit 20 is the processor-mode flag (PM), and bits 27:24 hold the priority level (IPL). The state machine has five states: IDLE, PUSH_PSW, PUSH_PC, FETCH_VEC and DONE. Its transitions are:
- IDLE→DONE when a fast interrupt is taken.
- IDLE→PUSH_PSW when a normal interrupt or an exception is taken.
- PUSH_PSW→PUSH_PC on memory ready.
- PUSH_PC→FETCH_VEC on memory ready.
- FETCH_VEC→DONE on memory ready.
- DONE→IDLE unconditionally.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, busy, done, ack, wake and mem_valid are all 0.
- R2: A normal interrupt is taken only when I=1 and the current IPL is strictly below irq_lvl. On acceptance, ack pulses for one cycle with ack_num=irq_num and ack_fast=0.
- R3: A fast interrupt is taken only when I=1 and the current IPL is below 15. When both a fast and a normal request are pending, the fast one is taken. Its ack pulse carries ack_fast=1 and ack_num=0.
- R4: An exception request is taken whatever the values of I and IPL, and it has priority over both interrupt kinds. It produces no ack, and the IPL in new_psw is left unchanged.
- R5: If U=1, usp_out takes cur_sp and the push stack starts at cur_isp. If U=0, usp_out takes cur_usp and the stack starts at cur_sp. At done, sp_out equals isp_out.
- R6: In new_psw, PM, I and U are cleared and IPL is replaced: 15 for a fast interrupt, irq_lvl for a normal one. The words that are saved are the status word as it was before this change.
- R7: Fast entry sets bk_pc=cur_pc, bk_psw=cur_psw and new_pc=fast_vec. It makes no memory access, and done is high in the cycle after acceptance.
- R8: Normal entry writes the status word at stack-4 and then the PC at stack-8. It then reads the vector at vec_base+4*irq_num, and new_pc gets the word that was read. isp_out is stack-8.
- R9: An exception number n below 0x100 reads its vector from 0xFFFFFFC0+4*n, with 32-bit wraparound. A number from 0x100 to 0x1FF reads from vec_base+4*(n mod 256). The pushes are the same as in R8.
- R10: While mem_valid is high and mem_ready is low, mem_valid, mem_write, mem_addr and mem_wdata stay unchanged.
- R11: wake pulses for one cycle on every accepted entry.
- R12: busy stays high from acceptance through the one-cycle done pulse. Requests that arrive while busy are not taken until the sequencer is back in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_psw | input | 32 | Live packed status word |
| cur_pc | input | 32 | Program counter to be saved |
| cur_sp | input | 32 | Live stack pointer |
| cur_isp | input | 32 | Interrupt stack pointer |
| cur_usp | input | 32 | User stack pointer |
| vec_base | input | 32 | Relocatable vector table base |
| fast_vec | input | 32 | Fast interrupt handler address |
| irq_req | input | 1 | Normal interrupt pending |
| irq_num | input | 8 | Normal interrupt number |
| irq_lvl | input | 4 | Normal interrupt priority level |
| fast_req | input | 1 | Fast interrupt pending |
| exc_req | input | 1 | Exception or trap pending |
| exc_num | input | 9 | Exception or trap number |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | New PC and state valid (one cycle) |
| new_pc | output | 32 | Handler address |
| new_psw | output | 32 | Status word for the handler |
| isp_out | output | 32 | Updated interrupt stack pointer |
| usp_out | output | 32 | Updated user stack pointer |
| sp_out | output | 32 | Live stack pointer after entry |
| bk_pc | output | 32 | Backup PC for the fast interrupt |
| bk_psw | output | 32 | Backup status word for the fast interrupt |
| ack | output | 1 | Interrupt acknowledge pulse |
| ack_fast | output | 1 | Acknowledge refers to the fast interrupt |
| ack_num | output | 8 | Accepted interrupt number |
| wake | output | 1 | Leave-sleep pulse on entry |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory request completes |
| mem_rdata | input | 32 | Memory read data |

## Verification
The assertions assume that the memory port never raises mem_ready unless mem_valid is high. They also assume that the request inputs and the core state inputs are not read while busy is high. The bench's memory model raises mem_ready only for a visible request, and only after a configurable number of stall cycles. It raises requests only at the falling edge while the sequencer is idle, except for one deliberate fast request held across a stalled entry. That case checks that the request waits until the sequence has ended.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    localparam int PSW_I_BIT   = 16;
    localparam int PSW_U_BIT   = 17;
    localparam int PSW_PM_BIT  = 20;
    localparam int PSW_IPL_LSB = 24;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PSW,
        ST_PUSH_PC,
        ST_FETCH_VEC,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_FAST,
        KIND_NORM,
        KIND_EXC
    } entry_kind_t;
endpackage

// File: rtl/irq_accept.sv
module irq_accept
    import irq_entry_pkg::*;
#(
    parameter int IPL_W = 4
) (
    input  logic             psw_ie,
    input  logic [IPL_W-1:0] cur_ipl,
    input  logic             irq_req,
    input  logic [IPL_W-1:0] irq_lvl,
    input  logic             fast_req,
    input  logic             exc_req,
    output logic             take,
    output entry_kind_t      kind
);
    localparam logic [IPL_W-1:0] IPL_TOP = '1;

    logic norm_ok;
    logic fast_ok;

    always_comb begin
        norm_ok = irq_req && psw_ie && (cur_ipl < irq_lvl);
        fast_ok = fast_req && psw_ie && (cur_ipl != IPL_TOP);
        if (exc_req) begin
            kind = KIND_EXC;
        end else if (fast_ok) begin
            kind = KIND_FAST;
        end else if (norm_ok) begin
            kind = KIND_NORM;
        end else begin
            kind = KIND_NONE;
        end
        take = (kind != KIND_NONE);
    end
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr
    import irq_entry_pkg::*;
#(
    parameter int              XLEN           = 32,
    parameter int              NUM_W          = 8,
    parameter int              EXC_W          = 9,
    parameter logic [XLEN-1:0] FIXED_VEC_BASE = 32'hFFFF_FFC0
) (
    input  entry_kind_t     kind,
    input  logic [NUM_W-1:0] irq_num,
    input  logic [EXC_W-1:0] exc_num,
    input  logic [XLEN-1:0]  base,
    output logic [XLEN-1:0]  addr
);
    localparam int PAD_W = XLEN - NUM_W - 2;

    logic [XLEN-1:0] irq_off;
    logic [XLEN-1:0] exc_off;
    logic            is_trap;

    generate
        if (EXC_W > NUM_W) begin : g_trap_range
            assign is_trap = |exc_num[EXC_W-1:NUM_W];
        end else begin : g_no_trap_range
            assign is_trap = 1'b0;
        end
    endgenerate

    assign irq_off = {{PAD_W{1'b0}}, irq_num, 2'b00};
    assign exc_off = {{PAD_W{1'b0}}, exc_num[NUM_W-1:0], 2'b00};

    always_comb begin
        unique case (kind)
            KIND_EXC: addr = is_trap ? (base + exc_off) : (FIXED_VEC_BASE + exc_off);
            default:  addr = base + irq_off;
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int              XLEN           = 32,
    parameter int              IPL_W          = 4,
    parameter int              NUM_W          = 8,
    parameter int              EXC_W          = 9,
    parameter logic [XLEN-1:0] FIXED_VEC_BASE = 32'hFFFF_FFC0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  cur_psw,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  cur_sp,
    input  logic [XLEN-1:0]  cur_isp,
    input  logic [XLEN-1:0]  cur_usp,
    input  logic [XLEN-1:0]  vec_base,
    input  logic [XLEN-1:0]  fast_vec,
    input  logic             irq_req,
    input  logic [NUM_W-1:0] irq_num,
    input  logic [IPL_W-1:0] irq_lvl,
    input  logic             fast_req,
    input  logic             exc_req,
    input  logic [EXC_W-1:0] exc_num,
    output logic             busy,
    output logic             done,
    output logic [XLEN-1:0]  new_pc,
    output logic [XLEN-1:0]  new_psw,
    output logic [XLEN-1:0]  isp_out,
    output logic [XLEN-1:0]  usp_out,
    output logic [XLEN-1:0]  sp_out,
    output logic [XLEN-1:0]  bk_pc,
    output logic [XLEN-1:0]  bk_psw,
    output logic             ack,
    output logic             ack_fast,
    output logic [NUM_W-1:0] ack_num,
    output logic             wake,
    output logic             mem_valid,
    output logic             mem_write,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic             mem_ready,
    input  logic [XLEN-1:0]  mem_rdata
);
    localparam logic [XLEN-1:0]  WORD_STEP = XLEN'(4);
    localparam logic [IPL_W-1:0] IPL_TOP   = '1;
    localparam logic [XLEN-1:0]  ONE       = XLEN'(1);
    localparam logic [XLEN-1:0]  IPL_FIELD = XLEN'({IPL_W{1'b1}}) << PSW_IPL_LSB;
    localparam logic [XLEN-1:0]  KEEP_MASK = ~((ONE << PSW_I_BIT) | (ONE << PSW_U_BIT) |
                                               (ONE << PSW_PM_BIT) | IPL_FIELD);

    function automatic logic [XLEN-1:0] enter_psw(input logic [XLEN-1:0] p,
                                                  input logic [IPL_W-1:0] lvl);
        return (p & KEEP_MASK) | (XLEN'(lvl) << PSW_IPL_LSB);
    endfunction

    seq_state_t      state_q, state_d;
    entry_kind_t     take_kind;
    logic            take;
    logic            accept;
    logic [XLEN-1:0] vec_addr_c;

    logic [XLEN-1:0] psw_q, pc_q, isp_q, usp_q, vec_q;
    logic [XLEN-1:0] new_pc_q, new_psw_q, bk_pc_q, bk_psw_q;
    logic            ack_q, ack_fast_q, wake_q;
    logic [NUM_W-1:0] ack_num_q;

    wire             psw_ie  = cur_psw[PSW_I_BIT];
    wire             psw_us  = cur_psw[PSW_U_BIT];
    wire [IPL_W-1:0] cur_ipl = cur_psw[PSW_IPL_LSB +: IPL_W];

    irq_accept #(.IPL_W(IPL_W)) u_accept (
        .psw_ie   (psw_ie),
        .cur_ipl  (cur_ipl),
        .irq_req  (irq_req),
        .irq_lvl  (irq_lvl),
        .fast_req (fast_req),
        .exc_req  (exc_req),
        .take     (take),
        .kind     (take_kind)
    );

    irq_vec_addr #(
        .XLEN           (XLEN),
        .NUM_W          (NUM_W),
        .EXC_W          (EXC_W),
        .FIXED_VEC_BASE (FIXED_VEC_BASE)
    ) u_vec (
        .kind    (take_kind),
        .irq_num (irq_num),
        .exc_num (exc_num),
        .base    (vec_base),
        .addr    (vec_addr_c)
    );

    assign accept = (state_q == ST_IDLE) && take;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    state_d = (take_kind == KIND_FAST) ? ST_DONE : ST_PUSH_PSW;
                end
            end
            ST_PUSH_PSW:  if (mem_ready) state_d = ST_PUSH_PC;
            ST_PUSH_PC:   if (mem_ready) state_d = ST_FETCH_VEC;
            ST_FETCH_VEC: if (mem_ready) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_PUSH_PSW: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = isp_q - WORD_STEP;
                mem_wdata = psw_q;
            end
            ST_PUSH_PC: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = isp_q - WORD_STEP;
                mem_wdata = pc_q;
            end
            ST_FETCH_VEC: begin
                mem_valid = 1'b1;
                mem_addr  = vec_q;
            end
            default: begin
                mem_valid = 1'b0;
            end
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psw_q      <= '0;
            pc_q       <= '0;
            isp_q      <= '0;
            usp_q      <= '0;
            vec_q      <= '0;
            new_pc_q   <= '0;
            new_psw_q  <= '0;
            bk_pc_q    <= '0;
            bk_psw_q   <= '0;
            ack_q      <= 1'b0;
            ack_fast_q <= 1'b0;
            ack_num_q  <= '0;
            wake_q     <= 1'b0;
        end else begin
            ack_q  <= 1'b0;
            wake_q <= 1'b0;
            if (accept) begin
                psw_q  <= cur_psw;
                pc_q   <= cur_pc;
                vec_q  <= vec_addr_c;
                wake_q <= 1'b1;
                isp_q  <= psw_us ? cur_isp : cur_sp;
                usp_q  <= psw_us ? cur_sp : cur_usp;
                unique case (take_kind)
                    KIND_FAST: begin
                        new_psw_q  <= enter_psw(cur_psw, IPL_TOP);
                        new_pc_q   <= fast_vec;
                        bk_pc_q    <= cur_pc;
                        bk_psw_q   <= cur_psw;
                        ack_q      <= 1'b1;
                        ack_fast_q <= 1'b1;
                        ack_num_q  <= '0;
                    end
                    KIND_NORM: begin
                        new_psw_q  <= enter_psw(cur_psw, irq_lvl);
                        ack_q      <= 1'b1;
                        ack_fast_q <= 1'b0;
                        ack_num_q  <= irq_num;
                    end
                    default: begin
                        new_psw_q  <= enter_psw(cur_psw, cur_ipl);
                    end
                endcase
            end else if (mem_ready) begin
                unique case (state_q)
                    ST_PUSH_PSW, ST_PUSH_PC: isp_q    <= isp_q - WORD_STEP;
                    ST_FETCH_VEC:            new_pc_q <= mem_rdata;
                    default:                 isp_q    <= isp_q;
                endcase
            end
        end
    end

    assign new_pc   = new_pc_q;
    assign new_psw  = new_psw_q;
    assign isp_out  = isp_q;
    assign sp_out   = isp_q;
    assign usp_out  = usp_q;
    assign bk_pc    = bk_pc_q;
    assign bk_psw   = bk_psw_q;
    assign ack      = ack_q;
    assign ack_fast = ack_fast_q;
    assign ack_num  = ack_num_q;
    assign wake     = wake_q;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
    import irq_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            ack,
    input logic            wake,
    input logic [XLEN-1:0] new_psw,
    input logic [XLEN-1:0] isp_out,
    input logic [XLEN-1:0] sp_out,
    input logic            mem_valid,
    input logic            mem_write,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic            mem_ready
);
    a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_write) &&
                                       $stable(mem_addr) && $stable(mem_wdata)));

    a_r2_ack_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    a_r2_ack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> busy);

    a_r11_wake_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    a_r12_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r12_memory_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (busy && !done));

    a_r6_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!new_psw[PSW_I_BIT] && !new_psw[PSW_U_BIT] && !new_psw[PSW_PM_BIT]));

    a_r5_live_sp_is_isp: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sp_out == isp_out));
endmodule

bind irq_entry_seq irq_entry_chk #(.XLEN(XLEN)) u_entry_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .ack       (ack),
    .wake      (wake),
    .new_psw   (new_psw),
    .isp_out   (isp_out),
    .sp_out    (sp_out),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_psw = '0, cur_pc = '0, cur_sp = '0, cur_isp = '0, cur_usp = '0;
    logic [31:0] vec_base = '0, fast_vec = '0;
    logic        irq_req = 1'b0, fast_req = 1'b0, exc_req = 1'b0;
    logic [7:0]  irq_num = '0;
    logic [3:0]  irq_lvl = '0;
    logic [8:0]  exc_num = '0;
    logic        busy, done, ack, ack_fast, wake, mem_valid, mem_write;
    logic [31:0] new_pc, new_psw, isp_out, usp_out, sp_out, bk_pc, bk_psw, mem_addr, mem_wdata;
    logic [7:0]  ack_num;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #4 clk = ~clk;

    irq_entry_seq i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .cur_psw(cur_psw), .cur_pc(cur_pc), .cur_sp(cur_sp),
        .cur_isp(cur_isp), .cur_usp(cur_usp), .vec_base(vec_base), .fast_vec(fast_vec),
        .irq_req(irq_req), .irq_num(irq_num), .irq_lvl(irq_lvl), .fast_req(fast_req),
        .exc_req(exc_req), .exc_num(exc_num), .busy(busy), .done(done), .new_pc(new_pc),
        .new_psw(new_psw), .isp_out(isp_out), .usp_out(usp_out), .sp_out(sp_out),
        .bk_pc(bk_pc), .bk_psw(bk_psw), .ack(ack), .ack_fast(ack_fast), .ack_num(ack_num),
        .wake(wake), .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] data;
    } mem_item_t;

    mem_item_t exp_q[$];
    int n_chk = 0;
    int n_fail = 0;
    int stall_cfg = 0;
    int ack_cnt = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_psw(input logic [31:0] p, input logic [3:0] lvl);
        return (p & ~32'h0F13_0000) | ({28'd0, lvl} << 24);
    endfunction

    // memory monitor: pops expected accesses and answers them
    initial begin
        int stall_cnt = 0;
        forever begin
            @(negedge clk);
            mem_ready = 1'b0;
            if (rst_n && mem_valid) begin
                if (stall_cnt < stall_cfg) begin
                    stall_cnt++;
                end else begin
                    stall_cnt = 0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7 unexpected memory access", mem_addr, 32'h0);
                    end else begin
                        mem_item_t it;
                        it = exp_q.pop_front();
                        chk(mem_write == it.wr, "R8 access direction", {31'd0, mem_write}, {31'd0, it.wr});
                        chk(mem_addr == it.addr, "R8/R9 access address", mem_addr, it.addr);
                        if (it.wr) chk(mem_wdata == it.data, "R8 pushed word", mem_wdata, it.data);
                        else mem_rdata = it.data;
                        mem_ready = 1'b1;
                    end
                end
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (ack) ack_cnt++;
        end
    end

    // driver: kind 0 refused, 1 fast, 2 normal, 3 exception
    task automatic entry(input string tag, input int kind, input logic [31:0] psw,
                         input bit fr, input bit ir, input bit er, input bit mid_fast);
        logic [31:0] isp0, usp_e, vec, hnd, pc_e;
        int wait_n;
        int acks_before;
        isp0  = psw[17] ? cur_isp : cur_sp;
        usp_e = psw[17] ? cur_sp : cur_usp;
        hnd   = 32'h4000_0000 + {23'd0, exc_num} + {24'd0, irq_num};
        if (kind == 3)
            vec = exc_num[8] ? vec_base + {22'd0, exc_num[7:0], 2'b00}
                             : 32'hFFFF_FFC0 + {22'd0, exc_num[7:0], 2'b00};
        else
            vec = vec_base + {22'd0, irq_num, 2'b00};
        if (kind >= 2) begin
            exp_q.push_back('{1'b1, isp0 - 32'd4, psw});
            exp_q.push_back('{1'b1, isp0 - 32'd8, cur_pc});
            exp_q.push_back('{1'b0, vec, hnd});
        end
        cur_psw = psw; fast_req = fr; irq_req = ir; exc_req = er;
        @(negedge clk);
        if (kind == 0) begin
            for (int k = 0; k < 3; k++) begin
                chk(!busy && !ack && !wake, {tag, " refused request not taken"}, {31'd0, busy}, 32'd0);
                @(negedge clk);
            end
            fast_req = 0; irq_req = 0; exc_req = 0;
            return;
        end
        chk(busy, {tag, " R12 busy after accept"}, {31'd0, busy}, 32'd1);
        chk(wake, {tag, " R11 wake pulse"}, {31'd0, wake}, 32'd1);
        chk(ack == (kind != 3), {tag, " R2/R4 ack pulse"}, {31'd0, ack}, {31'd0, kind != 3});
        if (kind == 1) chk(ack_fast && ack_num == 0, {tag, " R3 fast ack"}, {23'd0, ack_fast, ack_num}, 32'h100);
        if (kind == 2) chk(!ack_fast && ack_num == irq_num, {tag, " R2 ack number"}, {23'd0, ack_fast, ack_num}, {24'd0, irq_num});
        pc_e = cur_pc;
        fast_req = mid_fast; irq_req = 0; exc_req = 0;
        acks_before = ack_cnt;
        if (kind == 1) chk(done, {tag, " R7 done one cycle after accept"}, {31'd0, done}, 32'd1);
        wait_n = 0;
        while (!done && wait_n < 100) begin
            @(negedge clk);
            wait_n++;
        end
        if (mid_fast) chk(ack_cnt == acks_before, "R12 no accept while busy", ack_cnt, acks_before);
        chk(done, {tag, " R12 done reached"}, {31'd0, done}, 32'd1);
        if (kind == 1) begin
            chk(new_pc == fast_vec, "R7 fast new_pc", new_pc, fast_vec);
            chk(bk_pc == pc_e, "R7 backup pc", bk_pc, pc_e);
            chk(bk_psw == psw, "R7 backup psw", bk_psw, psw);
            chk(new_psw == exp_psw(psw, 4'd15), "R6 fast psw", new_psw, exp_psw(psw, 4'd15));
            chk(isp_out == isp0, "R5 fast isp", isp_out, isp0);
        end else begin
            chk(new_pc == hnd, {tag, " R8 new_pc from vector"}, new_pc, hnd);
            chk(isp_out == isp0 - 32'd8, {tag, " R8 isp after pushes"}, isp_out, isp0 - 32'd8);
            if (kind == 2) chk(new_psw == exp_psw(psw, irq_lvl), "R6 normal psw", new_psw, exp_psw(psw, irq_lvl));
            else chk(new_psw == exp_psw(psw, psw[27:24]), "R4 exception psw keeps IPL", new_psw, exp_psw(psw, psw[27:24]));
        end
        chk(usp_out == usp_e, {tag, " R5 usp"}, usp_out, usp_e);
        chk(sp_out == isp_out, {tag, " R5 live sp"}, sp_out, isp_out);
        @(negedge clk);
        chk(!done && !busy, {tag, " R12 done single cycle"}, {30'd0, busy, done}, 32'd0);
        chk(exp_q.size() == 0, {tag, " R8 all accesses made"}, exp_q.size(), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !ack && !wake && !mem_valid, "R1 reset state",
            {27'd0, busy, done, ack, wake, mem_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        cur_pc = 32'h0000_1234; cur_sp = 32'h0000_8000; cur_isp = 32'h0000_9000;
        cur_usp = 32'h0000_7000; vec_base = 32'h0010_0000; fast_vec = 32'h0020_0040;
        irq_num = 8'h21; irq_lvl = 4'd5;
        // R2 normal taken, U=0
        entry("R2 normal", 2, 32'h0301_0005, 0, 1, 0, 0);
        // R2 refused: level equal, and I clear
        entry("R2 equal level", 0, 32'h0501_0000, 0, 1, 0, 0);
        entry("R2 disabled", 0, 32'h0100_0000, 0, 1, 0, 0);
        // R3 fast taken, U=1, PM=1
        cur_pc = 32'h0000_2000;
        entry("R3 fast", 1, 32'h0E13_0003, 1, 0, 0, 0);
        entry("R3 fast at 15", 0, 32'h0F01_0000, 1, 0, 0, 0);
        // R3 both pending -> fast
        cur_pc = 32'h0000_2100;
        entry("R3 both", 1, 32'h0001_0000, 1, 1, 0, 0);
        // R4 exception with I=0, IPL=15, beats pending irq; number 23
        exc_num = 9'd23; cur_pc = 32'h0000_3000;
        entry("R4 R9 illegal", 3, 32'h0F00_0001, 1, 1, 1, 0);
        // R9 trap range
        exc_num = 9'h105;
        entry("R9 trap", 3, 32'h0203_0000, 0, 0, 1, 0);
        // R9 top of fixed table
        exc_num = 9'h0FF;
        entry("R9 fixed top", 3, 32'h0002_0000, 0, 0, 1, 0);
        exc_num = 9'd0;
        // R10 R12 stalled normal entry with fast request arriving mid-sequence
        stall_cfg = 3; irq_num = 8'h07; irq_lvl = 4'd9; cur_pc = 32'h0000_4000;
        entry("R10 stalled", 2, 32'h0101_0000, 0, 1, 0, 1);
        stall_cfg = 0; cur_pc = 32'h0000_4100;
        entry("R12 deferred fast", 1, 32'h0101_0000, 1, 0, 0, 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R12 actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule